// File: doc/BRIEF.md
# Microcode Sequencer with Packed Return Stack

This block picks the next microcode address, once per clock, for a microprogrammed 8-bit processor core. The microinstruction from the control store arrives on `uinstr`. The datapath supplies its ALU output and the byte currently on its data-in bus. A single read/write control bit comes from the core's output register. The block holds the microaddress register. It also keeps a copy of the most recent ALU result, which it uses to evaluate branch conditions.

Each cycle the block does one of the following:
- steps to the next address;
- branches to a literal address taken from the instruction;
- dispatches straight to the fetched opcode byte;
- holds in place.

It can also call and return from microcode subroutines through a return stack three entries deep, kept in one shifting register. A store microinstruction raises a write strobe for the attached memory in the same cycle it is presented.

Top module: `micro_seq`

## Requirements
- R1: While reset is applied, and for the two clocks after its release, `uaddr` is 0x7D0. Reset also clears the stored ALU result to zero and empties the return stack.
- R2: An instruction whose kind field `uinstr[31:28]` is not 1 advances `uaddr` by one on the next clock, wrapping from 0x7FF to 0x000. A control instruction (kind 1) whose condition field `uinstr[19:16]` is 3 or above 3 also advances by one.
- R3: A control instruction with condition 0 (always) and target source `uinstr[22:20]` = 0 loads `uaddr` with `uinstr[10:0]`. Literal bits 15:11 are ignored.
- R4: Condition 1 takes the branch only when the stored ALU result is nonzero. Condition 2 takes it only when that result is zero. When the branch is not taken, `uaddr` advances by one.
- R5: The stored ALU result loads `alu_result` only when the kind is greater than 1. Kinds 0 and 1 leave it unchanged.
- R6: A taken branch with target source 1 loads `uaddr` with `data_in`, zero-extended to 11 bits (opcode dispatch).
- R7: A taken branch with the call flag `uinstr[24]` = 1 pushes the current `uaddr`. A taken branch with target source 2 pops the newest entry and jumps to that entry plus one. Nested calls return in last-in, first-out order.
- R8: A fourth nested call discards the oldest entry. A return from an empty stack jumps to address 0x001.
- R9: `mem_wr` is 1, combinationally, exactly when the kind is 1, the condition is 3 and `wr_rd_n` is 0. That instruction does not branch.
- R10: A taken branch whose target source is 3 to 7 leaves `uaddr` unchanged.
- R11: A branch that is not taken pushes nothing, even when the call flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uinstr | input | 32 | Microinstruction read at the current `uaddr` |
| alu_result | input | 16 | ALU output of the datapath for this instruction |
| data_in | input | 8 | Byte on the core's data-in bus |
| wr_rd_n | input | 1 | Read/write bit of the output register (0 = write) |
| uaddr | output | 11 | Current microcode address |
| mem_wr | output | 1 | Write strobe to the attached memory |

## Verification
A wrong entry in the return stack stays invisible until the matching return. It then shows as a wrong `uaddr` one clock after the return microinstruction, which can be many cycles after the corrupting call. For that reason the bench nests calls past the stack depth and unwinds every level. A stale or wrongly loaded stored ALU result shows only through the next conditional branch: a taken/not-taken decision flipped one clock later. The stimulus therefore places conditional branches directly after non-loading kinds 0 and 1, as well as after loading ALU kinds.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int INSTR_W = 32;

  localparam logic [3:0] KIND_CTRL = 4'h1;

  localparam logic [3:0] COND_ALWAYS  = 4'h0;
  localparam logic [3:0] COND_NONZERO = 4'h1;
  localparam logic [3:0] COND_ZERO    = 4'h2;
  localparam logic [3:0] COND_STORE   = 4'h3;

  localparam logic [2:0] SRC_LIT  = 3'd0;
  localparam logic [2:0] SRC_DISP = 3'd1;
  localparam logic [2:0] SRC_RET  = 3'd2;

  typedef struct packed {
    logic [3:0]  kind;
    logic [2:0]  spare_hi;
    logic        call;
    logic        spare_lo;
    logic [2:0]  src;
    logic [3:0]  cond;
    logic [15:0] lit;
  } uinstr_t;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/seq_branch_eval.sv
module seq_branch_eval
  import seq_pkg::*;
#(
  parameter int RW = 16
) (
  input  logic [3:0]    kind,
  input  logic [3:0]    cond,
  input  logic [RW-1:0] last_result,
  input  logic          wr_rd_n,
  output logic          jump_taken,
  output logic          store_strobe,
  output logic          result_load
);

  logic is_ctrl;
  logic cond_met;

  assign is_ctrl = (kind == KIND_CTRL);

  always_comb begin
    unique case (cond)
      COND_ALWAYS:  cond_met = 1'b1;
      COND_NONZERO: cond_met = (last_result != '0);
      COND_ZERO:    cond_met = (last_result == '0);
      default:      cond_met = 1'b0;
    endcase
  end

  assign jump_taken   = is_ctrl && cond_met;
  assign store_strobe = is_ctrl && (cond == COND_STORE) && !wr_rd_n;
  assign result_load  = (kind > KIND_CTRL);

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int AW    = 11,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] ret_addr
);

  logic [DEPTH-1:0][AW-1:0] lvl_q;
  logic [DEPTH-1:0][AW-1:0] lvl_pushed;
  logic [DEPTH-1:0][AW-1:0] lvl_d;
  logic                     lvl_en;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_lvl
      if (g == 0) begin : g_top
        assign lvl_pushed[g] = push ? push_addr : lvl_q[g];
      end else begin : g_deep
        assign lvl_pushed[g] = push ? lvl_q[g-1] : lvl_q[g];
      end

      if (g == DEPTH-1) begin : g_last
        assign lvl_d[g] = pop ? '0 : lvl_pushed[g];
      end else begin : g_mid
        assign lvl_d[g] = pop ? lvl_pushed[g+1] : lvl_pushed[g];
      end
    end
  endgenerate

  assign lvl_en   = push | pop;
  assign ret_addr = lvl_pushed[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

endmodule

// File: rtl/seq_target_mux.sv
module seq_target_mux
  import seq_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic [2:0]    src,
  input  logic [AW-1:0] lit,
  input  logic [DW-1:0] data_in,
  input  logic [AW-1:0] ret_addr,
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] target
);

  always_comb begin
    unique case (src)
      SRC_LIT:  target = lit;
      SRC_DISP: target = AW'(data_in);
      SRC_RET:  target = ret_addr + AW'(1);
      default:  target = cur_addr;
    endcase
  end

endmodule

// File: rtl/micro_seq.sv
module micro_seq
  import seq_pkg::*;
#(
  parameter int            AW         = 11,
  parameter int            DW         = 8,
  parameter int            RW         = 16,
  parameter int            DEPTH      = 3,
  parameter logic [AW-1:0] RESET_ADDR = 11'h7D0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] uinstr,
  input  logic [RW-1:0]      alu_result,
  input  logic [DW-1:0]      data_in,
  input  logic               wr_rd_n,
  output logic [AW-1:0]      uaddr,
  output logic               mem_wr
);

  localparam int LIT_W = 16;

  uinstr_t       ins;
  logic          rst_sync_n;
  logic          jump_taken;
  logic          result_load;
  logic          stk_push;
  logic          stk_pop;
  logic [AW-1:0] ret_addr;
  logic [AW-1:0] target;
  logic [AW-1:0] uaddr_q;
  logic [AW-1:0] uaddr_d;
  logic [RW-1:0] last_q;
  logic [RW-1:0] last_d;
  logic          unused_bits;

  assign ins         = uinstr_t'(uinstr);
  assign unused_bits = ^{ins.spare_hi, ins.spare_lo, ins.lit[LIT_W-1:AW]};

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  seq_branch_eval #(.RW(RW)) u_eval (
    .kind         (ins.kind),
    .cond         (ins.cond),
    .last_result  (last_q),
    .wr_rd_n      (wr_rd_n),
    .jump_taken   (jump_taken),
    .store_strobe (mem_wr),
    .result_load  (result_load)
  );

  assign stk_push = jump_taken && ins.call;
  assign stk_pop  = jump_taken && (ins.src == SRC_RET);

  seq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_addr (uaddr_q),
    .ret_addr  (ret_addr)
  );

  seq_target_mux #(.AW(AW), .DW(DW)) u_tgt (
    .src      (ins.src),
    .lit      (ins.lit[AW-1:0]),
    .data_in  (data_in),
    .ret_addr (ret_addr),
    .cur_addr (uaddr_q),
    .target   (target)
  );

  // next state
  always_comb begin
    uaddr_d = jump_taken ? target : (uaddr_q + AW'(1));
    last_d  = alu_result;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) uaddr_q <= RESET_ADDR;
    else             uaddr_q <= uaddr_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)       last_q <= '0;
    else if (result_load)  last_q <= last_d;
  end

  assign uaddr = uaddr_q;

endmodule

// File: rtl/micro_seq_checker.sv
module micro_seq_checker #(
  parameter int            AW         = 11,
  parameter int            DW         = 8,
  parameter int            RW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = 11'h7D0
) (
  input logic          clk,
  input logic          srst_n,
  input logic [31:0]   uinstr,
  input logic [DW-1:0] data_in,
  input logic [RW-1:0] last_q,
  input logic [AW-1:0] ret_addr,
  input logic [AW-1:0] uaddr,
  input logic          mem_wr
);

  logic [3:0] kind;
  logic [3:0] cond;
  logic [2:0] src;
  logic       call;

  assign kind = uinstr[31:28];
  assign cond = uinstr[19:16];
  assign src  = uinstr[22:20];
  assign call = uinstr[24];

  // R1: address held at its reset value while the synchronized reset is low
  always @(negedge clk) begin
    if (!srst_n) begin
      p_reset_addr_r1: assert (uaddr == RESET_ADDR);
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (kind != 4'h1) |=> (uaddr == $past(uaddr) + AW'(1)));

  p_literal_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (kind == 4'h1 && cond == 4'h0 && src == 3'd0) |=> (uaddr == $past(uinstr[AW-1:0])));

  p_nz_untaken_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (kind == 4'h1 && cond == 4'h1 && last_q == '0) |=> (uaddr == $past(uaddr) + AW'(1)));

  p_last_keep_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (kind <= 4'h1) |=> $stable(last_q));

  p_dispatch_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (kind == 4'h1 && cond == 4'h0 && src == 3'd1) |=> (uaddr == AW'($past(data_in))));

  p_return_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (kind == 4'h1 && cond == 4'h0 && src == 3'd2 && !call) |=> (uaddr == $past(ret_addr) + AW'(1)));

  p_store_step_r9: assert property (@(posedge clk) disable iff (!srst_n)
    mem_wr |=> (uaddr == $past(uaddr) + AW'(1)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (kind == 4'h1 && cond == 4'h0 && src > 3'd2) |=> $stable(uaddr));

endmodule

bind micro_seq micro_seq_checker #(
  .AW(AW), .DW(DW), .RW(RW), .RESET_ADDR(RESET_ADDR)
) u_chk (
  .clk      (clk),
  .srst_n   (rst_sync_n),
  .uinstr   (uinstr),
  .data_in  (data_in),
  .last_q   (last_q),
  .ret_addr (ret_addr),
  .uaddr    (uaddr),
  .mem_wr   (mem_wr)
);

// File: tb/tb_micro_seq.sv
`timescale 1ns/1ps
module tb_micro_seq;

  localparam real HALF = 10.0;  // 50 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] uinstr = 32'h0;
  logic [15:0] alu_result = 16'h0;
  logic [7:0]  data_in = 8'h0;
  logic        wr_rd_n = 1'b1;
  logic [10:0] uaddr;
  logic        mem_wr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [10:0] addr;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #(HALF) clk = ~clk;

  micro_seq dut (
    .clk(clk), .rst_n(rst_n), .uinstr(uinstr), .alu_result(alu_result),
    .data_in(data_in), .wr_rd_n(wr_rd_n), .uaddr(uaddr), .mem_wr(mem_wr)
  );

  function automatic logic [31:0] ctl(input bit call, input logic [2:0] src,
                                      input logic [3:0] cond, input logic [15:0] lit);
    return {4'h1, 3'b000, call, 1'b0, src, cond, lit};
  endfunction

  function automatic logic [31:0] alu(input logic [3:0] kind);
    return {kind, 28'h0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // driver: present one microinstruction, check the strobe, queue the next address
  task automatic step(input logic [31:0] ins, input logic [15:0] res, input logic [7:0] din,
                      input logic rw, input logic exp_wr, input logic [10:0] exp_addr,
                      input string tag);
    exp_t e;
    uinstr = ins; alu_result = res; data_in = din; wr_rd_n = rw;
    #1;
    check({tag, " strobe"}, {31'h0, mem_wr}, {31'h0, exp_wr});
    e.addr = exp_addr; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare the registered address a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " addr"}, {21'h0, uaddr}, {21'h0, e.addr});
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 2 * HALF);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {21'h0, uaddr}, 32'h7D0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sync release", {21'h0, uaddr}, 32'h7D0);
    @(negedge clk);
    // stored result cleared by reset: zero branch taken
    step(ctl(0, 3'd0, 4'h2, 16'h0123), 16'hFFFF, 8'h00, 1, 0, 11'h123, "R1 result cleared");
    step(alu(4'h0), 16'h5555, 8'h00, 1, 0, 11'h124, "R2 kind0 step");
    step(alu(4'h2), 16'h0000, 8'h00, 1, 0, 11'h125, "R2 alu step");
    step(ctl(0, 3'd0, 4'h0, 16'hFFFE), 16'h0000, 8'h00, 1, 0, 11'h7FE, "R3 literal low bits");
    step(alu(4'h3), 16'h0000, 8'h00, 1, 0, 11'h7FF, "R2 step");
    step(alu(4'h4), 16'h1234, 8'h00, 1, 0, 11'h000, "R2 wrap");
    step(ctl(0, 3'd0, 4'h1, 16'h0100), 16'h0000, 8'h00, 1, 0, 11'h100, "R4 nonzero taken");
    step(ctl(0, 3'd0, 4'h2, 16'h0200), 16'h0000, 8'h00, 1, 0, 11'h101, "R4 zero untaken");
    step(alu(4'h0), 16'h0000, 8'h00, 1, 0, 11'h102, "R5 kind0 no load");
    step(ctl(0, 3'd0, 4'h1, 16'h0300), 16'h0000, 8'h00, 1, 0, 11'h300, "R5 result kept");
    step(ctl(0, 3'd0, 4'h5, 16'h0400), 16'h0000, 8'h00, 1, 0, 11'h301, "R2 other cond");
    step(alu(4'h2), 16'h0000, 8'h00, 1, 0, 11'h302, "R5 load zero");
    step(ctl(0, 3'd0, 4'h2, 16'h0050), 16'h0000, 8'h00, 1, 0, 11'h050, "R4 zero taken");
    step(ctl(0, 3'd0, 4'h1, 16'h0060), 16'h0000, 8'h00, 1, 0, 11'h051, "R4 nonzero untaken");
    step(ctl(0, 3'd1, 4'h0, 16'h0000), 16'h0000, 8'hA7, 1, 0, 11'h0A7, "R6 dispatch");
    step(ctl(0, 3'd0, 4'h3, 16'h0700), 16'h0000, 8'h00, 0, 1, 11'h0A8, "R9 store write");
    step(ctl(0, 3'd0, 4'h3, 16'h0700), 16'h0000, 8'h00, 1, 0, 11'h0A9, "R9 store read");
    step(ctl(1, 3'd0, 4'h0, 16'h0400), 16'h0000, 8'h00, 0, 0, 11'h400, "R7 call 1");
    step(ctl(1, 3'd0, 4'h0, 16'h0500), 16'h0000, 8'h00, 1, 0, 11'h500, "R7 call 2");
    step(ctl(1, 3'd0, 4'h0, 16'h0600), 16'h0000, 8'h00, 1, 0, 11'h600, "R7 call 3");
    step(ctl(1, 3'd0, 4'h0, 16'h0700), 16'h0000, 8'h00, 1, 0, 11'h700, "R8 call 4");
    step(ctl(0, 3'd2, 4'h0, 16'h0000), 16'h0000, 8'h00, 1, 0, 11'h601, "R7 return 3");
    step(ctl(0, 3'd2, 4'h0, 16'h0000), 16'h0000, 8'h00, 1, 0, 11'h501, "R7 return 2");
    step(ctl(0, 3'd2, 4'h0, 16'h0000), 16'h0000, 8'h00, 1, 0, 11'h401, "R7 return 1");
    step(ctl(0, 3'd2, 4'h0, 16'h0000), 16'h0000, 8'h00, 1, 0, 11'h001, "R8 oldest dropped");
    step(ctl(1, 3'd0, 4'h1, 16'h0700), 16'h0000, 8'h00, 1, 0, 11'h002, "R11 untaken call");
    step(ctl(0, 3'd2, 4'h0, 16'h0000), 16'h0000, 8'h00, 1, 0, 11'h001, "R11 nothing pushed");
    step(ctl(0, 3'd5, 4'h0, 16'h0123), 16'h0000, 8'h00, 1, 0, 11'h001, "R10 hold");
    step(alu(4'h0), 16'h0000, 8'h00, 1, 0, 11'h002, "R2 after hold");
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule